// File: doc/BRIEF.md
# Latched and Level Interrupt Controller

This block gathers a processor's interrupt sources into two request lines: a normal interrupt (`irq_out`) and a fast interrupt (`fiq_out`). The sources come in three kinds. Level inputs of either polarity are passed through a synchronizer and simply follow their pins. Rising-edge and falling-edge pins set a sticky bit. Internal events also set sticky bits: two timer reloads, power-on, serial receive-full and serial transmit-empty.

Software sees three 8-bit banks: normal A, normal B and fast. Each bank has a read-only status byte, a read/write mask byte and a read-only request byte. The request byte is status AND mask. `irq_out` is the OR of request A and request B, and `fiq_out` is the OR of the fast request. The edge, power-on and timer bits are released only by writing ones to the clear register. The two serial bits are released by the serial unit's data-read and data-write strobes. Bit 7 of status A and bit 7 of the fast status always read as one, so setting the matching mask bit forces an interrupt. There is no priority encoding.

Register map (4-bit `reg_addr`): 0x0 status A, 0x1 request A (read) and clear (write), 0x2 mask A, 0x4 status B, 0x5 request B, 0x6 mask B, 0x8 fast status, 0x9 fast request, 0xA fast mask. Every other address reads zero.

Top module: `irq_fiq_aggregator`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), all three masks read 0x00 and both outputs are low. Status A reads 0x90 (force bit 7 and power-on bit 4 set) while all inputs are idle. Status B reads 0x00 and the fast status reads 0x80.
- R2: Bit 7 of status A and bit 7 of the fast status always read 1, so a set mask bit 7 forces the matching output high.
- R3: Level bits are active-low and reach status two clock edges after the pin changes. `irq_lvl_n[7]` maps to status A bit 1, `irq_lvl_n[6]` to status A bit 0, and `irq_lvl_n[5:0]` to status B bits 5:0. Each bit reads 1 while its pin is low.
- R4: A high-to-low change on `edge_fall_in` sets status A bit 2, and a low-to-high change on `edge_rise_in` sets status A bit 3. The bit is set three clock edges after the pin change, not two. It stays set after the pin returns, and the opposite change on the same pin sets nothing.
- R5: Writing to address 0x1 clears each of status A bits 6:2 whose write-data bit is 1. Write-data bits that are 0 change nothing, and level and force bits are unaffected.
- R6: When a set event and a clear of the same latched bit arrive in the same cycle, the bit ends up set.
- R7: A one-cycle pulse on `tmr0_evt` sets status A bit 5, and a pulse on `tmr1_evt` sets bit 6, both at the next clock edge.
- R8: `rx_full_evt` sets status B bit 7 and `rx_data_rd` clears it. `tx_empty_evt` sets status B bit 6 and `tx_data_wr` clears it. Each strobe touches only its own bit.
- R9: Masks at 0x2, 0x6 and 0xA read back the value written. Each request byte reads status AND mask.
- R10: `irq_out` is high exactly when request A or request B is non-zero. `fiq_out` is high exactly when the fast request is non-zero.
- R11: Fast status bits are: bit 0 = `fiq_lvl_hi[0]`, bit 1 = `fiq_lvl_hi[1]`, bit 2 = NOT `fiq_lvl_n`, bits 5:3 = NOT `ctl_lvl_n[2:0]`, bit 6 = 0, bit 7 = 1. Each bit appears two clock edges after its pin changes.
- R12: Unmapped addresses read 0x00. Writes to status or request addresses other than 0x1 change no mask and no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset; also sets the power-on bit |
| irq_lvl_n | input | 8 | Active-low level sources for the normal interrupt |
| edge_fall_in | input | 1 | Falling-edge source pin |
| edge_rise_in | input | 1 | Rising-edge source pin |
| fiq_lvl_hi | input | 2 | Active-high fast level sources |
| fiq_lvl_n | input | 1 | Active-low fast level source |
| ctl_lvl_n | input | 3 | Active-low control-port sources for the fast bank |
| tmr0_evt | input | 1 | Timer 0 reload pulse |
| tmr1_evt | input | 1 | Timer 1 reload pulse |
| rx_full_evt | input | 1 | Serial receive-full pulse |
| rx_data_rd | input | 1 | Serial receive data read strobe |
| tx_empty_evt | input | 1 | Serial transmit-empty pulse |
| tx_data_wr | input | 1 | Serial transmit data write strobe |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| irq_out | output | 1 | Normal interrupt request, active high |
| fiq_out | output | 1 | Fast interrupt request, active high |

## Verification
On every cycle the assertions check several cycle-local rules. A latched edge bit holds unless it is cleared. Clearing the power-on bit takes effect on the next edge. A timer pulse always wins over a clear in the same cycle. A receive read drops the receive-full bit. Mask writes land as written. The force bits read as one, and an output stays low while every mask in its group is zero.

The exact pin-to-status latency of two edges for levels and three for edges can only be shown by the bench's timed scenarios. The same holds for the full mapping of every level pattern to its bit position, and for the AND of status and mask across all 256 mask values in each bank. The bench's sweeps cover each of these.

// File: rtl/irqagg_pkg.sv
// Package: shared register map, bit positions and widths for the
// latched/level interrupt controller.
// Assumes an 8-bit register bus and a 4-bit register address.
package irqagg_pkg;

    localparam int REG_W     = 8;
    localparam int ADDR_W    = 4;
    localparam int NUM_BANKS = 3;

    // Register addresses (request A address doubles as the clear register).
    localparam logic [ADDR_W-1:0] ADDR_STAT_A = 4'h0;
    localparam logic [ADDR_W-1:0] ADDR_REQ_A  = 4'h1;
    localparam logic [ADDR_W-1:0] ADDR_MASK_A = 4'h2;
    localparam logic [ADDR_W-1:0] ADDR_STAT_B = 4'h4;
    localparam logic [ADDR_W-1:0] ADDR_REQ_B  = 4'h5;
    localparam logic [ADDR_W-1:0] ADDR_MASK_B = 4'h6;
    localparam logic [ADDR_W-1:0] ADDR_STAT_F = 4'h8;
    localparam logic [ADDR_W-1:0] ADDR_REQ_F  = 4'h9;
    localparam logic [ADDR_W-1:0] ADDR_MASK_F = 4'hA;

    // Status A latched field: bits LATA_LO .. LATA_LO+LATA_W-1
    // (fall, rise, power-on, timer0, timer1 from low to high).
    localparam int LATA_LO = 2;
    localparam int LATA_W  = 5;
    localparam int FORCE_BIT = 7;

    // Status B latched field: tx-empty in bit 6, rx-full in bit 7.
    localparam int LATB_LO = 6;
    localparam int LATB_W  = 2;

    // Bank index for the three mask/request banks.
    typedef enum logic [1:0] {
        BANK_A = 2'd0,
        BANK_B = 2'd1,
        BANK_F = 2'd2
    } bank_e;

    // Mask register address of a bank.
    function automatic logic [ADDR_W-1:0] mask_addr_of(input int bank);
        case (bank)
            0:       return ADDR_MASK_A;
            1:       return ADDR_MASK_B;
            default: return ADDR_MASK_F;
        endcase
    endfunction

endpackage

// File: rtl/irqagg_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous pins.
// Each bit passes through STAGES flops; reset loads RST_VAL so idle
// pins do not look like events after reset.
module irqagg_sync #(
    parameter int           W       = 8,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    // First stage samples the pin.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= RST_VAL;
        else        stage_q[0] <= d;
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            // Later stages shift the sample along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/irqagg_latch.sv
// Module: vector of sticky event bits. A set pulse makes a bit 1; a
// clear pulse makes it 0; set wins when both arrive in one cycle.
// Reset loads RST_VAL (used to mark power-on).
module irqagg_latch #(
    parameter int           W       = 5,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q
);

    // Hold, clear, then apply set with priority.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= (q & ~clr_i) | set_i;
    end

endmodule

// File: rtl/irqagg_bank.sv
// Module: one mask/request bank. Holds the mask register written at
// MASK_ADDR and forms request = status & mask and its OR-reduction.
// Mask resets to zero so nothing fires before software enables it.
module irqagg_bank
    import irqagg_pkg::*;
#(
    parameter logic [ADDR_W-1:0] MASK_ADDR = ADDR_MASK_A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [REG_W-1:0]  status,
    output logic [REG_W-1:0]  mask,
    output logic [REG_W-1:0]  req,
    output logic              any_req
);

    logic mask_we;

    // Decode this bank's mask write.
    assign mask_we = reg_wr && (reg_addr == MASK_ADDR);

    // Mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_we) mask <= reg_wdata;
    end

    // Request bits and their reduction.
    always_comb begin
        req     = status & mask;
        any_req = |req;
    end

endmodule

// File: rtl/irq_fiq_aggregator.sv
// Module: top of the interrupt controller. Synchronizes external pins,
// detects edges against the previous synchronized sample, keeps the
// sticky event bits, assembles the three status bytes, and feeds them
// to three mask/request banks whose reductions form irq_out / fiq_out.
// Assumes internal event pulses are already in the clk domain.
module irq_fiq_aggregator
    import irqagg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        irq_lvl_n,
    input  logic              edge_fall_in,
    input  logic              edge_rise_in,
    input  logic [1:0]        fiq_lvl_hi,
    input  logic              fiq_lvl_n,
    input  logic [2:0]        ctl_lvl_n,
    input  logic              tmr0_evt,
    input  logic              tmr1_evt,
    input  logic              rx_full_evt,
    input  logic              rx_data_rd,
    input  logic              tx_empty_evt,
    input  logic              tx_data_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq_out,
    output logic              fiq_out
);

    localparam int FQ_W = 6;
    localparam logic [FQ_W-1:0] FQ_IDLE   = 6'b111100;
    localparam logic [1:0]      EDGE_IDLE = 2'b01;   // {rise, fall}
    localparam logic [LATA_W-1:0] LATA_RST = 5'b00100; // power-on set

    logic [7:0]        lvl_s;
    logic [FQ_W-1:0]   fq_s;
    logic [1:0]        edge_s;
    logic [1:0]        edge_prev;
    logic              fall_evt;
    logic              rise_evt;
    logic              clr_wr;
    logic [LATA_W-1:0] lat_a;
    logic [LATA_W-1:0] lat_a_set;
    logic [LATA_W-1:0] lat_a_clr;
    logic [LATB_W-1:0] lat_b;
    logic [REG_W-1:0]  status_a;
    logic [REG_W-1:0]  status_b;
    logic [REG_W-1:0]  status_f;
    logic [REG_W-1:0]  mask_a;
    logic [REG_W-1:0]  mask_b;
    logic [REG_W-1:0]  mask_f;
    logic [REG_W-1:0]  stat_arr [NUM_BANKS];
    logic [REG_W-1:0]  mask_arr [NUM_BANKS];
    logic [REG_W-1:0]  req_arr  [NUM_BANKS];
    logic [NUM_BANKS-1:0] any_arr;

    irqagg_sync #(.W(8), .STAGES(SYNC_STAGES), .RST_VAL(8'hFF)) u_sync_lvl (
        .clk(clk), .rst_n(rst_n), .d(irq_lvl_n), .q(lvl_s)
    );

    irqagg_sync #(.W(FQ_W), .STAGES(SYNC_STAGES), .RST_VAL(FQ_IDLE)) u_sync_fq (
        .clk(clk), .rst_n(rst_n),
        .d({ctl_lvl_n, fiq_lvl_n, fiq_lvl_hi}), .q(fq_s)
    );

    irqagg_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(EDGE_IDLE)) u_sync_edge (
        .clk(clk), .rst_n(rst_n),
        .d({edge_rise_in, edge_fall_in}), .q(edge_s)
    );

    // Previous synchronized edge sample for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) edge_prev <= EDGE_IDLE;
        else        edge_prev <= edge_s;
    end

    // Edge detection and clear-register decode.
    always_comb begin
        fall_evt  = edge_prev[0] & ~edge_s[0];
        rise_evt  = edge_s[1] & ~edge_prev[1];
        clr_wr    = reg_wr && (reg_addr == ADDR_REQ_A);
        lat_a_set = {tmr1_evt, tmr0_evt, 1'b0, rise_evt, fall_evt};
        lat_a_clr = clr_wr ? reg_wdata[LATA_LO +: LATA_W] : '0;
    end

    irqagg_latch #(.W(LATA_W), .RST_VAL(LATA_RST)) u_lat_a (
        .clk(clk), .rst_n(rst_n), .set_i(lat_a_set), .clr_i(lat_a_clr), .q(lat_a)
    );

    irqagg_latch #(.W(LATB_W), .RST_VAL('0)) u_lat_b (
        .clk(clk), .rst_n(rst_n),
        .set_i({rx_full_evt, tx_empty_evt}),
        .clr_i({rx_data_rd, tx_data_wr}),
        .q(lat_b)
    );

    // Assemble the three status bytes.
    always_comb begin
        status_a = {1'b1, lat_a, ~lvl_s[7], ~lvl_s[6]};
        status_b = {lat_b, ~lvl_s[5:0]};
        status_f = {1'b1, 1'b0, ~fq_s[5:2], fq_s[1:0]};
    end

    assign stat_arr[BANK_A] = status_a;
    assign stat_arr[BANK_B] = status_b;
    assign stat_arr[BANK_F] = status_f;

    genvar b;
    generate
        for (b = 0; b < NUM_BANKS; b++) begin : g_bank
            irqagg_bank #(.MASK_ADDR(mask_addr_of(b))) u_bank (
                .clk(clk), .rst_n(rst_n),
                .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
                .status(stat_arr[b]), .mask(mask_arr[b]),
                .req(req_arr[b]), .any_req(any_arr[b])
            );
        end
    endgenerate

    assign mask_a = mask_arr[BANK_A];
    assign mask_b = mask_arr[BANK_B];
    assign mask_f = mask_arr[BANK_F];

    // Output request lines.
    assign irq_out = any_arr[BANK_A] | any_arr[BANK_B];
    assign fiq_out = any_arr[BANK_F];

    // Register read multiplexer.
    always_comb begin
        case (reg_addr)
            ADDR_STAT_A: reg_rdata = status_a;
            ADDR_REQ_A:  reg_rdata = req_arr[BANK_A];
            ADDR_MASK_A: reg_rdata = mask_a;
            ADDR_STAT_B: reg_rdata = status_b;
            ADDR_REQ_B:  reg_rdata = req_arr[BANK_B];
            ADDR_MASK_B: reg_rdata = mask_b;
            ADDR_STAT_F: reg_rdata = status_f;
            ADDR_REQ_F:  reg_rdata = req_arr[BANK_F];
            ADDR_MASK_F: reg_rdata = mask_f;
            default:     reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irqagg_checker.sv
// Module: assertion checker bound to irq_fiq_aggregator. Watches ports
// and the status/mask state across clock edges.
module irqagg_checker
    import irqagg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              irq_out,
    input logic              fiq_out,
    input logic              tmr0_evt,
    input logic              rx_full_evt,
    input logic              rx_data_rd,
    input logic [REG_W-1:0]  stat_a,
    input logic [REG_W-1:0]  stat_b,
    input logic [REG_W-1:0]  mask_a,
    input logic [REG_W-1:0]  mask_b,
    input logic [REG_W-1:0]  mask_f
);

    logic rst_seen;
    logic clr_wr;

    // Records that a reset edge has been observed.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_seen <= 1'b1;
    end

    assign clr_wr = reg_wr && (reg_addr == ADDR_REQ_A);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_seen && $past(!rst_n)) |-> (stat_a[4] && mask_a == 0 && mask_b == 0 && mask_f == 0));

    assert_force_reads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_seen && (reg_addr == ADDR_STAT_A || reg_addr == ADDR_STAT_F)) |-> reg_rdata[FORCE_BIT]);

    assert_edge_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_seen && stat_a[3] && !(clr_wr && reg_wdata[3])) |=> stat_a[3]);

    assert_por_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_seen && clr_wr && reg_wdata[4]) |=> !stat_a[4]);

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_seen && tmr0_evt) |=> stat_a[5]);

    assert_rx_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_seen && rx_data_rd && !rx_full_evt) |=> !stat_b[7]);

    assert_mask_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_seen && reg_wr && reg_addr == ADDR_MASK_A) |=> (mask_a == $past(reg_wdata)));

    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_seen && mask_a == 0 && mask_b == 0) |-> !irq_out);

    assert_fiq_forced_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_seen && mask_f[FORCE_BIT]) |-> fiq_out);

endmodule

bind irq_fiq_aggregator irqagg_checker u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out),
    .fiq_out(fiq_out), .tmr0_evt(tmr0_evt), .rx_full_evt(rx_full_evt),
    .rx_data_rd(rx_data_rd), .stat_a(status_a), .stat_b(status_b),
    .mask_a(mask_a), .mask_b(mask_b), .mask_f(mask_f)
);

// File: tb/tb_irq_fiq_aggregator.sv
// Bench: sweeps level patterns, fast-bank inputs and all mask values,
// plus timed edge, timer, serial and clear scenarios.
module tb_irq_fiq_aggregator;

    localparam logic [3:0] A_STA = 4'h0, A_REQ = 4'h1, A_MSK = 4'h2;
    localparam logic [3:0] B_STA = 4'h4, B_REQ = 4'h5, B_MSK = 4'h6;
    localparam logic [3:0] F_STA = 4'h8, F_REQ = 4'h9, F_MSK = 4'hA;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_lvl_n = 8'hFF;
    logic       edge_fall_in = 1'b1;
    logic       edge_rise_in = 1'b0;
    logic [1:0] fiq_lvl_hi = 2'b00;
    logic       fiq_lvl_n = 1'b1;
    logic [2:0] ctl_lvl_n = 3'b111;
    logic       tmr0_evt = 1'b0, tmr1_evt = 1'b0;
    logic       rx_full_evt = 1'b0, rx_data_rd = 1'b0;
    logic       tx_empty_evt = 1'b0, tx_data_wr = 1'b0;
    logic [3:0] reg_addr = 4'h0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_out, fiq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    irq_fiq_aggregator dut (
        .clk(clk), .rst_n(rst_n), .irq_lvl_n(irq_lvl_n),
        .edge_fall_in(edge_fall_in), .edge_rise_in(edge_rise_in),
        .fiq_lvl_hi(fiq_lvl_hi), .fiq_lvl_n(fiq_lvl_n), .ctl_lvl_n(ctl_lvl_n),
        .tmr0_evt(tmr0_evt), .tmr1_evt(tmr1_evt),
        .rx_full_evt(rx_full_evt), .rx_data_rd(rx_data_rd),
        .tx_empty_evt(tx_empty_evt), .tx_data_wr(tx_data_wr),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out), .fiq_out(fiq_out)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] e;
        settle(4);
        rst_n = 1'b1;
        settle(1);

        // R1: reset state
        rd(A_MSK, d); chk("R1", "mask A", d, 8'h00);
        rd(B_MSK, d); chk("R1", "mask B", d, 8'h00);
        rd(F_MSK, d); chk("R1", "mask F", d, 8'h00);
        rd(A_STA, d); chk("R1", "status A", d, 8'h90);
        rd(B_STA, d); chk("R1", "status B", d, 8'h00);
        rd(F_STA, d); chk("R1", "fast status", d, 8'h80);
        chk("R1", "irq_out", {7'd0, irq_out}, 8'h00);
        chk("R1", "fiq_out", {7'd0, fiq_out}, 8'h00);

        // R5: zero write leaves power-on set, one clears it
        wr(A_REQ, 8'h00); rd(A_STA, d); chk("R5", "clear zero", d, 8'h90);
        wr(A_REQ, 8'h10); rd(A_STA, d); chk("R5", "clear power-on", d, 8'h80);

        // R3: sweep all level patterns
        for (int v = 0; v < 256; v++) begin
            @(negedge clk); irq_lvl_n = v[7:0];
            settle(2);
            e = 8'h80 | {6'd0, ~v[7], ~v[6]};
            rd(A_STA, d); chk("R3", "status A level", d, e);
            e = {2'b00, ~v[5:0]};
            rd(B_STA, d); chk("R3", "status B level", d, e);
        end
        @(negedge clk); irq_lvl_n = 8'hFF; settle(3);

        // R11: sweep fast-bank inputs
        for (int v = 0; v < 64; v++) begin
            @(negedge clk);
            fiq_lvl_hi = v[1:0]; fiq_lvl_n = v[2]; ctl_lvl_n = v[5:3];
            settle(2);
            e = {2'b10, ~v[5:2], v[1:0]};
            rd(F_STA, d); chk("R11", "fast status", d, e);
        end
        @(negedge clk); fiq_lvl_hi = 2'b00; fiq_lvl_n = 1'b1; ctl_lvl_n = 3'b111; settle(3);

        // R2: force bit reads 1 and drives outputs through the mask
        wr(A_MSK, 8'h80); chk("R2", "irq forced", {7'd0, irq_out}, 8'h01);
        wr(F_MSK, 8'h80); chk("R2", "fiq forced", {7'd0, fiq_out}, 8'h01);
        wr(A_MSK, 8'h00); wr(F_MSK, 8'h00);

        // R4: falling edge latency and hold
        @(negedge clk); edge_fall_in = 1'b0;
        settle(2); rd(A_STA, d); chk("R4", "fall before third edge", d, 8'h80);
        settle(1); rd(A_STA, d); chk("R4", "fall latched", d, 8'h84);
        @(negedge clk); edge_fall_in = 1'b1; settle(4);
        rd(A_STA, d); chk("R4", "fall held, opposite ignored", d, 8'h84);
        // R4: rising edge, then opposite change ignored
        @(negedge clk); edge_rise_in = 1'b1; settle(3);
        rd(A_STA, d); chk("R4", "rise latched", d, 8'h8C);
        wr(A_REQ, 8'h08); rd(A_STA, d); chk("R5", "clear rise only", d, 8'h84);
        @(negedge clk); edge_rise_in = 1'b0; settle(4);
        rd(A_STA, d); chk("R4", "rise pin fall ignored", d, 8'h84);
        wr(A_REQ, 8'h04); rd(A_STA, d); chk("R5", "clear fall", d, 8'h80);

        // R7: timer pulses
        @(negedge clk); tmr0_evt = 1'b1; @(negedge clk); tmr0_evt = 1'b0;
        rd(A_STA, d); chk("R7", "timer0", d, 8'hA0);
        @(negedge clk); tmr1_evt = 1'b1; @(negedge clk); tmr1_evt = 1'b0;
        rd(A_STA, d); chk("R7", "timer1", d, 8'hE0);
        wr(A_REQ, 8'h20); rd(A_STA, d); chk("R5", "clear timer0 only", d, 8'hC0);
        wr(A_REQ, 8'h7C); rd(A_STA, d); chk("R5", "clear many", d, 8'h80);

        // R6: set and clear in one cycle
        @(negedge clk);
        tmr0_evt = 1'b1; reg_addr = A_REQ; reg_wdata = 8'h20; reg_wr = 1'b1;
        @(negedge clk); tmr0_evt = 1'b0; reg_wr = 1'b0;
        rd(A_STA, d); chk("R6", "set wins", d, 8'hA0);
        wr(A_REQ, 8'h20);

        // R8: serial bits
        @(negedge clk); rx_full_evt = 1'b1; @(negedge clk); rx_full_evt = 1'b0;
        rd(B_STA, d); chk("R8", "rx full", d, 8'h80);
        @(negedge clk); tx_empty_evt = 1'b1; @(negedge clk); tx_empty_evt = 1'b0;
        rd(B_STA, d); chk("R8", "tx empty", d, 8'hC0);
        @(negedge clk); rx_data_rd = 1'b1; @(negedge clk); rx_data_rd = 1'b0;
        rd(B_STA, d); chk("R8", "rx read clears", d, 8'h40);
        @(negedge clk); tx_data_wr = 1'b1; @(negedge clk); tx_data_wr = 1'b0;
        rd(B_STA, d); chk("R8", "tx write clears", d, 8'h00);

        // R9 / R10: full mask sweeps against a fixed status
        @(negedge clk); irq_lvl_n = 8'b0011_1100; fiq_lvl_hi = 2'b01; settle(3);
        for (int m = 0; m < 256; m++) begin
            wr(A_MSK, m[7:0]);
            rd(A_MSK, d); chk("R9", "mask A readback", d, m[7:0]);
            rd(A_REQ, d); chk("R9", "request A", d, 8'h83 & m[7:0]);
            chk("R10", "irq from A", {7'd0, irq_out}, {7'd0, |(8'h83 & m[7:0])});
        end
        wr(A_MSK, 8'h00);
        for (int m = 0; m < 256; m++) begin
            wr(B_MSK, m[7:0]);
            rd(B_MSK, d); chk("R9", "mask B readback", d, m[7:0]);
            rd(B_REQ, d); chk("R9", "request B", d, 8'h03 & m[7:0]);
            chk("R10", "irq from B", {7'd0, irq_out}, {7'd0, |(8'h03 & m[7:0])});
        end
        wr(B_MSK, 8'h00);
        for (int m = 0; m < 256; m++) begin
            wr(F_MSK, m[7:0]);
            rd(F_MSK, d); chk("R9", "mask F readback", d, m[7:0]);
            rd(F_REQ, d); chk("R9", "request F", d, 8'h81 & m[7:0]);
            chk("R10", "fiq", {7'd0, fiq_out}, {7'd0, |(8'h81 & m[7:0])});
        end
        wr(F_MSK, 8'h00);

        // R12: unmapped reads and writes without effect
        rd(4'h3, d); chk("R12", "addr 3", d, 8'h00);
        rd(4'h7, d); chk("R12", "addr 7", d, 8'h00);
        for (int a = 11; a < 16; a++) begin
            rd(a[3:0], d); chk("R12", "upper addr", d, 8'h00);
        end
        @(negedge clk); tmr1_evt = 1'b1; @(negedge clk); tmr1_evt = 1'b0;
        wr(A_STA, 8'hFF); rd(A_STA, d); chk("R12", "status A write ignored", d, 8'hC3);
        wr(B_REQ, 8'hFF); rd(B_MSK, d); chk("R12", "request B write ignored", d, 8'h00);
        rd(A_STA, d); chk("R12", "no clear via B", d, 8'hC3);
        wr(F_STA, 8'hFF); rd(F_MSK, d); chk("R12", "fast status write ignored", d, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule